// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps the per-source state for a group of hardware interrupt sources. Each source is typed once as either level-sensitive or message style. Each source holds a destination server number, a priority, a saved priority and four status flags: line asserted, handed out, bounced back and arrived-while-masked. A single presentation unit sits downstream. It receives delivery offers, and it can bounce an offer back (reject), ask for a full replay (resend) or signal completion (end of interrupt).

Sources are numbered globally as their local index plus the parameter `BASE`. Offers carry that global number. Reject and end-of-interrupt requests give a global number, and the block subtracts `BASE` to find the local entry. An offer is held on a valid/ready output register. Pending offers drain lowest index first, one per cycle. A resend walks all sources in index order, one per cycle, and holds `busy` high while it runs.

Top module: `irq_source_ctrl`

## Requirements
- R1: After reset, `dlv_valid` and `busy` are 0. Every source reads back server 0, priority 0xFF and saved priority 0xFF on the query port, one cycle after `qry_idx` is applied.
- R2: A source whose priority is 0xFF (masked) is never offered. No offer ever carries priority 0xFF.
- R3: `dlv_num` equals the local index plus `BASE`. A reject or end-of-interrupt number below `BASE` or at or above `BASE + N_SRC` changes no source.
- R4: A rising edge on a masked message source is remembered. A later configuration write with a priority other than 0xFF offers that source exactly once and forgets the arrival. A write that keeps it masked offers nothing.
- R5: A rising edge on an unmasked message source produces one offer carrying its stored server and priority. A configuration write stores server, priority and saved priority.
- R6: A level source is offered when its line changes to high while it is unmasked and not already handed out. It is not offered again until an end-of-interrupt or a reject clears the handed-out flag and a resend, a line change or a configuration write re-checks it.
- R7: A configuration write that unmasks a level source whose line is high and which is not handed out offers it at once.
- R8: A reject marks a message source as bounced, and the next resend re-offers it once if it is unmasked. A reject clears a level source's handed-out flag.
- R9: A resend visits sources in ascending index. Several bounced sources are offered in ascending order. A bounced masked source loses its bounced flag without being offered. The scan lasts `N_SRC` cycles.
- R10: An end-of-interrupt on a message source has no effect. A following resend offers nothing for it.
- R11: While `dlv_ready` is low, a pending offer stays on the outputs unchanged. Offers raised in the same cycle are presented lowest index first.
- R12: `busy` rises the cycle after a resend request accepted while idle. Configuration writes and rejects presented while `busy` is high are ignored.
- R13: The level/message type of each source survives reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| type_we | input | 1 | Loads the source type vector |
| type_level | input | N_SRC | 1 = level source, 0 = message source |
| src_line | input | N_SRC | Interrupt lines from the sources |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Local source index being configured |
| cfg_server | input | SRV_W | Destination server |
| cfg_prio | input | PRIO_W | Priority, all ones = masked |
| cfg_saved_prio | input | PRIO_W | Saved priority |
| rej_valid | input | 1 | Reject request strobe |
| rej_num | input | NUM_W | Global number being rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number being completed |
| resend_req | input | 1 | Starts a resend scan |
| busy | output | 1 | Resend scan in progress |
| qry_idx | input | IDX_W | Local index to read back |
| qry_server | output | SRV_W | Stored server of `qry_idx` (registered) |
| qry_prio | output | PRIO_W | Stored priority of `qry_idx` (registered) |
| qry_saved_prio | output | PRIO_W | Stored saved priority of `qry_idx` (registered) |
| dlv_valid | output | 1 | Offer present |
| dlv_ready | input | 1 | Presentation unit takes the offer |
| dlv_num | output | NUM_W | Global source number of the offer |
| dlv_server | output | SRV_W | Server of the offer |
| dlv_prio | output | PRIO_W | Priority of the offer |

## Verification
The checker watches on every cycle that no offer carries the masked priority, that every offered number lies inside the block's global window, and that a stalled offer keeps its number, server and priority. It also checks that an accepted resend raises `busy` and that a scan never runs longer than one cycle per source. What only the scenarios can show is the state held between events. That covers a masked message arrival replayed by a later unmask, a level source staying quiet while handed out, bounced sources coming back in index order, and requests ignored because they fall outside the window, target a message source or arrive during a scan.

// File: rtl/irqsrc_pkg.sv
package irqsrc_pkg;
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;
endpackage

// File: rtl/irqsrc_line_tracker.sv
// Registers the raw source lines and reports edges against the stored level.
module irqsrc_line_tracker #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] line_i,
  output logic [N_SRC-1:0] rise_o,
  output logic [N_SRC-1:0] change_o
);
  logic [N_SRC-1:0] level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= '0;
    else     level_q <= line_i;
  end

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_edge
      assign rise_o[g]   = line_i[g] & ~level_q[g];
      assign change_o[g] = line_i[g] ^ level_q[g];
    end
  endgenerate
endmodule

// File: rtl/irqsrc_lowest_pick.sv
// Fixed-priority picker: the lowest set index wins.
module irqsrc_lowest_pick #(
  parameter int N_SRC = 8,
  parameter int IDX_W = 3
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irqsrc_resend_scan.sv
// Walks every source index once, one per cycle, after a start pulse.
module irqsrc_resend_scan
  import irqsrc_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output logic             busy_o,
  output logic             step_o,
  output logic [IDX_W-1:0] step_idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_SRC - 1);

  scan_state_e      state_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SCAN_IDLE;
      idx_q   <= '0;
    end else begin
      case (state_q)
        SCAN_IDLE: begin
          idx_q <= '0;
          if (start_i) state_q <= SCAN_RUN;
        end
        SCAN_RUN: begin
          if (idx_q == LAST) state_q <= SCAN_IDLE;
          idx_q <= idx_q + 1'b1;
        end
        default: state_q <= SCAN_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q == SCAN_RUN);
  assign step_o     = busy_o;
  assign step_idx_o = idx_q;
endmodule

// File: rtl/irq_source_ctrl.sv
// Per-source interrupt state with a valid/ready delivery output.
module irq_source_ctrl #(
  parameter int N_SRC  = 8,
  parameter int SRV_W  = 4,
  parameter int PRIO_W = 8,
  parameter int NUM_W  = 12,
  parameter int BASE   = 16,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              type_we,
  input  logic [N_SRC-1:0]  type_level,
  input  logic [N_SRC-1:0]  src_line,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [SRV_W-1:0]  cfg_server,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic [PRIO_W-1:0] cfg_saved_prio,
  input  logic              rej_valid,
  input  logic [NUM_W-1:0]  rej_num,
  input  logic              eoi_valid,
  input  logic [NUM_W-1:0]  eoi_num,
  input  logic              resend_req,
  output logic              busy,
  input  logic [IDX_W-1:0]  qry_idx,
  output logic [SRV_W-1:0]  qry_server,
  output logic [PRIO_W-1:0] qry_prio,
  output logic [PRIO_W-1:0] qry_saved_prio,
  output logic              dlv_valid,
  input  logic              dlv_ready,
  output logic [NUM_W-1:0]  dlv_num,
  output logic [SRV_W-1:0]  dlv_server,
  output logic [PRIO_W-1:0] dlv_prio
);
  localparam int IDX_SPAN = 1 << IDX_W;
  localparam logic [IDX_SPAN-1:0] IDX_LEGAL = {IDX_SPAN{1'b1}} >> (IDX_SPAN - N_SRC);
  localparam logic [PRIO_W-1:0]   PRIO_OFF  = {PRIO_W{1'b1}};
  localparam logic [NUM_W-1:0]    NUM_BASE  = NUM_W'(BASE);
  localparam logic [NUM_W-1:0]    NUM_SPAN  = NUM_W'(N_SRC);

  // Per-source storage
  logic [SRV_W-1:0]  srv_q  [N_SRC];
  logic [PRIO_W-1:0] prio_q [N_SRC];
  logic [PRIO_W-1:0] sav_q  [N_SRC];
  logic [N_SRC-1:0]  lvl_q;     // type, not cleared by reset
  logic [N_SRC-1:0]  sent_q, bounce_q, mpend_q, offer_q;
  logic [N_SRC-1:0]  sent_d, bounce_d, mpend_d, offer_d;
  logic [N_SRC-1:0]  open_v;

  // Sub-block wires
  logic [N_SRC-1:0]  rise, change;
  logic              pick_hit;
  logic [IDX_W-1:0]  pick_idx;
  logic              step;
  logic [IDX_W-1:0]  step_idx;

  irqsrc_line_tracker #(.N_SRC(N_SRC)) u_lines (
    .clk(clk), .rst(rst), .line_i(src_line), .rise_o(rise), .change_o(change)
  );

  irqsrc_resend_scan #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_scan (
    .clk(clk), .rst(rst), .start_i(resend_req), .busy_o(busy),
    .step_o(step), .step_idx_o(step_idx)
  );

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_open
      assign open_v[g] = (prio_q[g] != PRIO_OFF);
    end
  endgenerate

  irqsrc_lowest_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
    .req_i(offer_q & open_v), .hit_o(pick_hit), .idx_o(pick_idx)
  );

  // Request decode
  logic             take, issue, cfg_go, rej_go, eoi_go;
  logic [NUM_W-1:0] rej_off, eoi_off;
  logic [IDX_W-1:0] rej_loc, eoi_loc;

  assign take    = !dlv_valid || dlv_ready;
  assign issue   = take && pick_hit;
  assign cfg_go  = cfg_we && !busy && IDX_LEGAL[cfg_idx];
  assign rej_off = rej_num - NUM_BASE;
  assign eoi_off = eoi_num - NUM_BASE;
  assign rej_loc = rej_off[IDX_W-1:0];
  assign eoi_loc = eoi_off[IDX_W-1:0];
  assign rej_go  = rej_valid && !busy && (rej_num >= NUM_BASE) && (rej_off < NUM_SPAN);
  assign eoi_go  = eoi_valid && (eoi_num >= NUM_BASE) && (eoi_off < NUM_SPAN);

  // Status next state: issue, line events, config, scan step, reject, completion
  always_comb begin
    sent_d   = sent_q;
    bounce_d = bounce_q;
    mpend_d  = mpend_q;
    offer_d  = offer_q;
    if (issue) offer_d[pick_idx] = 1'b0;

    for (int i = 0; i < N_SRC; i++) begin
      if (lvl_q[i]) begin
        if (change[i] && src_line[i] && open_v[i] && !sent_d[i]) begin
          sent_d[i]  = 1'b1;
          offer_d[i] = 1'b1;
        end
      end else if (rise[i]) begin
        if (open_v[i]) offer_d[i] = 1'b1;
        else           mpend_d[i] = 1'b1;
      end
    end

    if (cfg_go) begin
      if (cfg_prio == PRIO_OFF) begin
        if (offer_d[cfg_idx]) begin
          offer_d[cfg_idx] = 1'b0;
          if (lvl_q[cfg_idx]) sent_d[cfg_idx]  = 1'b0;
          else                mpend_d[cfg_idx] = 1'b1;
        end
      end else if (lvl_q[cfg_idx]) begin
        if (src_line[cfg_idx] && !sent_d[cfg_idx]) begin
          sent_d[cfg_idx]  = 1'b1;
          offer_d[cfg_idx] = 1'b1;
        end
      end else if (mpend_d[cfg_idx]) begin
        mpend_d[cfg_idx] = 1'b0;
        offer_d[cfg_idx] = 1'b1;
      end
    end

    if (step) begin
      if (lvl_q[step_idx]) begin
        if (open_v[step_idx] && src_line[step_idx] && !sent_d[step_idx]) begin
          sent_d[step_idx]  = 1'b1;
          offer_d[step_idx] = 1'b1;
        end
      end else if (bounce_d[step_idx]) begin
        bounce_d[step_idx] = 1'b0;
        if (open_v[step_idx]) offer_d[step_idx] = 1'b1;
      end
    end

    if (rej_go) begin
      bounce_d[rej_loc] = 1'b1;
      sent_d[rej_loc]   = 1'b0;
    end

    if (eoi_go && lvl_q[eoi_loc]) sent_d[eoi_loc] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (type_we) lvl_q <= type_level;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sent_q   <= '0;
      bounce_q <= '0;
      mpend_q  <= '0;
      offer_q  <= '0;
      for (int i = 0; i < N_SRC; i++) begin
        srv_q[i]  <= '0;
        prio_q[i] <= PRIO_OFF;
        sav_q[i]  <= PRIO_OFF;
      end
    end else begin
      sent_q   <= sent_d;
      bounce_q <= bounce_d;
      mpend_q  <= mpend_d;
      offer_q  <= offer_d;
      if (cfg_go) begin
        srv_q[cfg_idx]  <= cfg_server;
        prio_q[cfg_idx] <= cfg_prio;
        sav_q[cfg_idx]  <= cfg_saved_prio;
      end
    end
  end

  // Delivery output register
  always_ff @(posedge clk) begin
    if (rst) begin
      dlv_valid  <= 1'b0;
      dlv_num    <= '0;
      dlv_server <= '0;
      dlv_prio   <= '0;
    end else if (take) begin
      dlv_valid <= pick_hit;
      if (pick_hit) begin
        dlv_num    <= NUM_BASE + NUM_W'(pick_idx);
        dlv_server <= srv_q[pick_idx];
        dlv_prio   <= prio_q[pick_idx];
      end
    end
  end

  // Configuration read-back
  always_ff @(posedge clk) begin
    if (rst) begin
      qry_server     <= '0;
      qry_prio       <= '0;
      qry_saved_prio <= '0;
    end else if (IDX_LEGAL[qry_idx]) begin
      qry_server     <= srv_q[qry_idx];
      qry_prio       <= prio_q[qry_idx];
      qry_saved_prio <= sav_q[qry_idx];
    end else begin
      qry_server     <= '0;
      qry_prio       <= '0;
      qry_saved_prio <= '0;
    end
  end
endmodule

// File: rtl/irqsrc_checker.sv
module irqsrc_checker #(
  parameter int N_SRC  = 8,
  parameter int SRV_W  = 4,
  parameter int PRIO_W = 8,
  parameter int NUM_W  = 12,
  parameter int BASE   = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              resend_req,
  input logic              dlv_valid,
  input logic              dlv_ready,
  input logic [NUM_W-1:0]  dlv_num,
  input logic [SRV_W-1:0]  dlv_server,
  input logic [PRIO_W-1:0] dlv_prio
);
  int busy_run;

  always_ff @(posedge clk) begin
    if (rst)       busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= 0;
  end

  p_masked_never_r2: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |-> (dlv_prio != {PRIO_W{1'b1}}));

  p_num_window_r3: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |-> ((dlv_num >= NUM_W'(BASE)) && (dlv_num < NUM_W'(BASE + N_SRC))));

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && !dlv_ready) |=>
      (dlv_valid && $stable(dlv_num) && $stable(dlv_server) && $stable(dlv_prio)));

  p_busy_start_r12: assert property (@(posedge clk) disable iff (rst)
    (resend_req && !busy) |=> busy);

  p_scan_bound_r9: assert property (@(posedge clk) disable iff (rst)
    busy_run <= N_SRC);
endmodule

bind irq_source_ctrl irqsrc_checker #(
  .N_SRC(N_SRC), .SRV_W(SRV_W), .PRIO_W(PRIO_W), .NUM_W(NUM_W), .BASE(BASE)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .resend_req(resend_req),
  .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_num(dlv_num),
  .dlv_server(dlv_server), .dlv_prio(dlv_prio)
);

// File: tb/sim_irq_source_ctrl.sv
module sim_irq_source_ctrl;
  localparam int N = 8, SRV_W = 4, PRIO_W = 8, NUM_W = 12, BASE = 16, IDX_W = 3;
  localparam int EW = NUM_W + SRV_W + PRIO_W;

  logic clk = 1'b0, rst = 1'b1;
  logic type_we = 1'b0;
  logic [N-1:0] type_level = '0, src_line = '0;
  logic cfg_we = 1'b0;
  logic [IDX_W-1:0] cfg_idx = '0, qry_idx = '0;
  logic [SRV_W-1:0] cfg_server = '0;
  logic [PRIO_W-1:0] cfg_prio = '0, cfg_saved_prio = '0;
  logic rej_valid = 1'b0, eoi_valid = 1'b0, resend_req = 1'b0, dlv_ready = 1'b1;
  logic [NUM_W-1:0] rej_num = '0, eoi_num = '0;
  logic busy, dlv_valid;
  logic [SRV_W-1:0] qry_server, dlv_server;
  logic [PRIO_W-1:0] qry_prio, qry_saved_prio, dlv_prio;
  logic [NUM_W-1:0] dlv_num;

  irq_source_ctrl #(.N_SRC(N), .SRV_W(SRV_W), .PRIO_W(PRIO_W), .NUM_W(NUM_W), .BASE(BASE)) u0 (
    .clk(clk), .rst(rst), .type_we(type_we), .type_level(type_level), .src_line(src_line),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_server(cfg_server), .cfg_prio(cfg_prio),
    .cfg_saved_prio(cfg_saved_prio), .rej_valid(rej_valid), .rej_num(rej_num),
    .eoi_valid(eoi_valid), .eoi_num(eoi_num), .resend_req(resend_req), .busy(busy),
    .qry_idx(qry_idx), .qry_server(qry_server), .qry_prio(qry_prio),
    .qry_saved_prio(qry_saved_prio), .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
    .dlv_num(dlv_num), .dlv_server(dlv_server), .dlv_prio(dlv_prio)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  string cur_req = "R5";
  logic [EW-1:0] exp_q[$];
  logic [EW-1:0] got_w, exp_w;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // Monitor: compares each accepted offer with the scoreboard head
  always @(negedge clk) begin
    if (!rst && dlv_valid && dlv_ready) begin
      got_w = {dlv_num, dlv_server, dlv_prio};
      if (exp_q.size() == 0) begin
        chk(1'b0, cur_req, "unexpected offer", longint'(got_w), 0);
      end else begin
        exp_w = exp_q.pop_front();
        chk(got_w == exp_w, cur_req, "offer", longint'(got_w), longint'(exp_w));
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_offer(input int idx, input int srv, input int pri);
    exp_q.push_back({NUM_W'(BASE + idx), SRV_W'(srv), PRIO_W'(pri)});
  endtask

  task automatic cfg(input int idx, input int srv, input int pri, input int sav);
    while (busy) tick();
    cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_server = SRV_W'(srv);
    cfg_prio = PRIO_W'(pri); cfg_saved_prio = PRIO_W'(sav);
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic reject(input int num);
    while (busy) tick();
    rej_valid = 1'b1; rej_num = NUM_W'(num);
    tick();
    rej_valid = 1'b0;
  endtask

  task automatic eoi(input int num);
    eoi_valid = 1'b1; eoi_num = NUM_W'(num);
    tick();
    eoi_valid = 1'b0;
  endtask

  task automatic resend();
    while (busy) tick();
    resend_req = 1'b1;
    tick();
    resend_req = 1'b0;
    while (busy) tick();
  endtask

  task automatic line(input int idx, input bit v);
    src_line[idx] = v;
    tick();
  endtask

  task automatic drained(input string req);
    repeat (N + 6) tick();
    chk(exp_q.size() == 0, req, "outstanding offers", exp_q.size(), 0);
  endtask

  task automatic query(input int idx, input int srv, input int pri, input int sav, input string req);
    qry_idx = IDX_W'(idx);
    tick();
    chk(qry_server == SRV_W'(srv), req, "query server", qry_server, srv);
    chk(qry_prio == PRIO_W'(pri), req, "query priority", qry_prio, pri);
    chk(qry_saved_prio == PRIO_W'(sav), req, "query saved priority", qry_saved_prio, sav);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    // Sources 0..3 message, 4..7 level
    type_we = 1'b1; type_level = 8'hF0;
    repeat (3) tick();
    type_we = 1'b0; rst = 1'b0;
    tick();
    cur_req = "R1";
    chk(dlv_valid == 1'b0, "R1", "dlv_valid after reset", dlv_valid, 0);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    query(3, 0, 255, 255, "R1");

    // R5: unmasked message edge
    cur_req = "R5";
    cfg(0, 2, 5, 9);
    query(0, 2, 5, 9, "R5");
    expect_offer(0, 2, 5);
    line(0, 1); line(0, 0);
    drained("R5");

    // R2 / R4: masked message arrival remembered
    cur_req = "R2";
    line(1, 1); line(1, 0);
    drained("R2");
    cur_req = "R4";
    cfg(1, 3, 255, 0);
    drained("R4");
    expect_offer(1, 3, 7);
    cfg(1, 3, 7, 0);
    drained("R4");
    cfg(1, 3, 6, 0);
    drained("R4");

    // R6: level source
    cur_req = "R6";
    cfg(4, 1, 4, 0);
    expect_offer(4, 1, 4);
    line(4, 1);
    drained("R6");
    resend();
    drained("R6");
    eoi(BASE + 4);
    expect_offer(4, 1, 4);
    resend();
    drained("R6");
    line(4, 0);
    eoi(BASE + 4);
    drained("R6");

    // R7: unmask of an asserted level source
    cur_req = "R7";
    line(5, 1);
    drained("R7");
    expect_offer(5, 6, 3);
    cfg(5, 6, 3, 0);
    drained("R7");
    line(5, 0);
    eoi(BASE + 5);

    // R8: reject then resend for a message source
    cur_req = "R8";
    reject(BASE + 0);
    expect_offer(0, 2, 5);
    resend();
    drained("R8");
    resend();
    drained("R8");

    // R9: ascending replay, masked bounced source dropped
    cur_req = "R9";
    cfg(2, 4, 2, 0);
    reject(BASE + 2); reject(BASE + 0); reject(BASE + 3);
    expect_offer(0, 2, 5);
    expect_offer(2, 4, 2);
    resend();
    drained("R9");
    resend();
    drained("R9");

    // R10: completion on a message source
    cur_req = "R10";
    eoi(BASE + 0);
    resend();
    drained("R10");

    // R3: out-of-window reject / completion
    cur_req = "R3";
    expect_offer(4, 1, 4);
    line(4, 1);
    drained("R3");
    eoi(BASE + 4 + N); eoi(BASE - 12); reject(BASE + N); reject(BASE - 1);
    resend();
    drained("R3");
    eoi(BASE + 4);
    expect_offer(4, 1, 4);
    resend();
    drained("R3");
    line(4, 0);
    eoi(BASE + 4);

    // R11: stall and simultaneous arrivals
    cur_req = "R11";
    dlv_ready = 1'b0;
    expect_offer(0, 2, 5);
    expect_offer(2, 4, 2);
    src_line[0] = 1'b1; src_line[2] = 1'b1;
    repeat (4) tick();
    chk(dlv_valid == 1'b1, "R11", "offer waiting", dlv_valid, 1);
    chk(dlv_num == NUM_W'(BASE), "R11", "lowest index first", dlv_num, BASE);
    tick();
    chk(dlv_num == NUM_W'(BASE) && dlv_prio == 8'd5, "R11", "held offer", dlv_num, BASE);
    dlv_ready = 1'b1;
    src_line[0] = 1'b0; src_line[2] = 1'b0;
    drained("R11");

    // R12: busy and ignored requests
    cur_req = "R12";
    resend_req = 1'b1;
    tick();
    resend_req = 1'b0;
    chk(busy == 1'b1, "R12", "busy after request", busy, 1);
    cfg_we = 1'b1; cfg_idx = 3'd3; cfg_server = 4'd7; cfg_prio = 8'd1; cfg_saved_prio = 8'd1;
    rej_valid = 1'b1; rej_num = NUM_W'(BASE + 1);
    tick();
    cfg_we = 1'b0; rej_valid = 1'b0;
    begin
      int waited = 0;
      while (busy && waited < 4 * N) begin tick(); waited++; end
      chk(busy == 1'b0, "R12", "scan finished", busy, 0);
    end
    query(3, 0, 255, 255, "R12");
    resend();
    drained("R12");

    // R13: type survives reset
    cur_req = "R13";
    rst = 1'b1;
    repeat (2) tick();
    rst = 1'b0;
    tick();
    query(0, 0, 255, 255, "R1");
    cfg(6, 5, 2, 0);
    expect_offer(6, 5, 2);
    line(6, 1);
    drained("R13");
    resend();
    drained("R13");
    eoi(BASE + 6);
    expect_offer(6, 5, 2);
    resend();
    drained("R13");
    line(6, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule